// File: doc/BRIEF.md
# Configurable 3x3 / 9-Tap Convolver

The block is a pipelined sum-of-products engine for 8-bit samples and 8-bit weights. It runs either as a two-dimensional 3x3 kernel convolver, fed by three row streams that external line buffers supply in lock-step, or as a one-dimensional 9-tap FIR filter fed by one stream. A register block outside this design holds the nine weights (named A to I) and a 4-bit configuration word; both reach the block as plain parallel vectors. The result is 20 bits wide, which holds any nine-product sum without overflow. One result leaves per clock in steady state, so a frame of R rows of C pixels takes R*C clocks.

The configuration word selects unsigned or two's-complement arithmetic, the topology and an optional output rounding. A hold input freezes the whole pipeline one clock after it is sampled. An active-low frame input clears the pipeline and the output asynchronously between frames. It does not touch the weights or the configuration, which live outside the block.

A small pipeline controller tracks the pipeline state. The states are `ST_EMPTY` (no tagged sample in flight), `ST_FLOW` (tagged samples in flight) and `ST_FROZEN` (the next clock edge is skipped). From `ST_EMPTY` or `ST_FLOW` a sampled hold goes to `ST_FROZEN`. From `ST_EMPTY` a valid input goes to `ST_FLOW`. `ST_FLOW` drops back to `ST_EMPTY` when no valid input arrives and no valid tag is left in the pipeline. `ST_FROZEN` leaves, on a low hold, to `ST_FLOW` or `ST_EMPTY` by the same test. The frame reset forces `ST_EMPTY`.

Top module: `conv3x3_engine`

## Requirements
- R1: With `cfg_mode[0]`=0, samples and weights are unsigned values from 0 to 255, and the result is their nine-product sum taken modulo 2^20.
- R2: With `cfg_mode[0]`=1, samples and weights are two's-complement values from -128 to 127, and the result is the signed sum written as a 20-bit two's-complement value.
- R3: With `cfg_mode[1]`=0, the block is a 9-tap FIR on row bus 0 (`pix_rows[7:0]`). For the sample taken at edge n, the result is A*d(n-8)+B*d(n-7)+...+H*d(n-1)+I*d(n). Weight A is `coef_vec[7:0]` and weight k (A=0 ... I=8) is `coef_vec[8k+7:8k]`.
- R4: With `cfg_mode[1]`=1, the block sums a 3x3 window. Row bus r is `pix_rows[8r+7:8r]`. Bus 0 is weighted by A,B,C, bus 1 by D,E,F and bus 2 by G,H,I. Within each row, the first weight applies to the sample taken two edges earlier and the third weight to the newest sample.
- R5: In 1-D mode the values on row buses 1 and 2 have no effect on the result.
- R6: With `cfg_mode[3:2]`=01, 8 is added to the sum, and result bits 3:0 are then forced to zero.
- R7: With `cfg_mode[3:2]`=10, 2048 is added to the sum, and result bits 11:0 are then forced to zero. The codes 00 and 11 both leave the sum unrounded.
- R8: A sample taken at a clock edge appears on `out_data` after the third following active edge, four active edges in all. `out_valid` carries that sample's `in_valid` tag, and a new result can follow on every clock.
- R9: If `hold` is high at an edge, the next edge changes no state: `out_data`, `out_valid` and every pipeline register keep their values, and the inputs at that edge are not taken.
- R10: While `frame_n` is low, `out_data` and `out_valid` are zero at once and stay zero, and every pipeline register is cleared. After release, samples taken before the reset contribute zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| frame_n | input | 1 | Asynchronous active-low frame reset of the pipeline |
| hold | input | 1 | Freeze request, takes effect on the following edge |
| cfg_mode | input | 4 | bit 0 signed, bit 1 2-D topology, bits 3:2 rounding code |
| coef_vec | input | 72 | Nine 8-bit weights, A in bits 7:0 up to I in bits 71:64 |
| pix_rows | input | 24 | Three 8-bit row samples, row r in bits 8r+7:8r |
| in_valid | input | 1 | Tag carried with the sample through the pipeline |
| out_data | output | 20 | Filtered result |
| out_valid | output | 1 | Tag of the sample that produced `out_data` |

## Verification
Random streams are run in 1-D and 2-D mode, each with unsigned and signed arithmetic. Comparing the two topologies on the same weights shows whether taps and weights are paired in the right order and whether row buses feed the right window rows. In 1-D mode the unused buses carry noise, so any leak from them shows at the output. Rounding runs use all-ones unsigned data, which gives the largest sum and exposes a carry lost at the top bit. Random hold patterns, a lone valid pulse and a frame reset in mid-stream separate a hold that acts one clock early, or not at all, from a correct one, and show whether stale window contents survive a reset.

// File: rtl/conv_pkg.sv
package conv_pkg;
    localparam int PIX_W   = 8;
    localparam int COEF_W  = 8;
    localparam int OUT_W   = 20;
    localparam int KDIM    = 3;
    localparam int NTAP    = KDIM * KDIM;
    localparam int PROD_W  = PIX_W + COEF_W + 2;
    localparam int SUM_W   = PROD_W + $clog2(NTAP);
    localparam int STAGES  = 4;
    localparam int HI_KEEP = 16;
    localparam int LO_KEEP = 8;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_FLOW   = 2'd1,
        ST_FROZEN = 2'd2
    } pipe_state_t;

    typedef enum logic [1:0] {
        RND_NONE = 2'b00,
        RND_TO16 = 2'b01,
        RND_TO8  = 2'b10,
        RND_RSVD = 2'b11
    } rnd_mode_t;

    typedef struct packed {
        rnd_mode_t rnd;
        logic      two_d;
        logic      signed_mode;
    } cfg_t;
endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
    import conv_pkg::*;
#(
    parameter int NSTG = conv_pkg::STAGES
) (
    input  logic            clk,
    input  logic            frame_n,
    input  logic            hold,
    input  logic            in_valid,
    input  logic [NSTG-1:0] vld_pipe,
    output pipe_state_t     state,
    output logic            advance
);
    pipe_state_t state_nx;
    logic        busy;

    assign busy = in_valid || (|vld_pipe);

    always_ff @(posedge clk or negedge frame_n) begin
        if (!frame_n) state <= ST_EMPTY;
        else          state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                if (hold)          state_nx = ST_FROZEN;
                else if (in_valid) state_nx = ST_FLOW;
            end
            ST_FLOW: begin
                if (hold)          state_nx = ST_FROZEN;
                else if (!busy)    state_nx = ST_EMPTY;
            end
            ST_FROZEN: begin
                if (!hold)         state_nx = busy ? ST_FLOW : ST_EMPTY;
            end
            default:               state_nx = ST_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_FROZEN: advance = 1'b0;
            default:   advance = 1'b1;
        endcase
    end
endmodule

// File: rtl/conv_window.sv
module conv_window #(
    parameter int PIX_W = conv_pkg::PIX_W,
    parameter int KDIM  = conv_pkg::KDIM
) (
    input  logic                             clk,
    input  logic                             frame_n,
    input  logic                             advance,
    input  logic                             two_d,
    input  logic                             in_valid,
    input  logic [KDIM-1:0][PIX_W-1:0]       rows_in,
    output logic [KDIM*KDIM-1:0][PIX_W-1:0]  taps,
    output logic                             taps_valid
);
    localparam int NTAP = KDIM * KDIM;

    logic [NTAP-1:0][PIX_W-1:0] feed;

    // Block b of KDIM taps is fed by row KDIM-1-b in 2-D mode; in 1-D mode
    // the blocks are chained into one NTAP-long delay line on row 0.
    for (genvar t = 0; t < NTAP; t++) begin : g_feed
        if (t % KDIM != 0) begin : g_shift
            assign feed[t] = taps[t-1];
        end else if (t == 0) begin : g_head
            assign feed[t] = two_d ? rows_in[KDIM-1] : rows_in[0];
        end else begin : g_join
            assign feed[t] = two_d ? rows_in[KDIM-1-(t/KDIM)] : taps[t-1];
        end
    end

    always_ff @(posedge clk or negedge frame_n) begin
        if (!frame_n) begin
            taps       <= '0;
            taps_valid <= 1'b0;
        end else if (advance) begin
            taps       <= feed;
            taps_valid <= in_valid;
        end
    end
endmodule

// File: rtl/conv_mac.sv
module conv_mac #(
    parameter int PIX_W  = conv_pkg::PIX_W,
    parameter int COEF_W = conv_pkg::COEF_W,
    parameter int NTAP   = conv_pkg::NTAP,
    parameter int SUM_W  = conv_pkg::SUM_W
) (
    input  logic                          clk,
    input  logic                          frame_n,
    input  logic                          advance,
    input  logic                          signed_mode,
    input  logic [NTAP-1:0][PIX_W-1:0]    taps,
    input  logic [NTAP-1:0][COEF_W-1:0]   coefs,
    input  logic                          taps_valid,
    output logic signed [SUM_W-1:0]       sum_q,
    output logic                          prod_valid,
    output logic                          sum_valid
);
    localparam int PROD_W = PIX_W + COEF_W + 2;

    logic signed [PROD_W-1:0] prod_c [NTAP];
    logic signed [PROD_W-1:0] prod_q [NTAP];
    logic signed [SUM_W-1:0]  sum_c;

    // Weight c pairs with tap NTAP-1-c: A meets the oldest sample.
    for (genvar c = 0; c < NTAP; c++) begin : g_mul
        logic signed [PIX_W:0]  px;
        logic signed [COEF_W:0] cf;
        assign px        = {signed_mode & taps[NTAP-1-c][PIX_W-1], taps[NTAP-1-c]};
        assign cf        = {signed_mode & coefs[c][COEF_W-1], coefs[c]};
        assign prod_c[c] = px * cf;
    end

    always_comb begin
        sum_c = '0;
        for (int c = 0; c < NTAP; c++) begin
            sum_c = sum_c + SUM_W'(prod_q[c]);
        end
    end

    always_ff @(posedge clk or negedge frame_n) begin
        if (!frame_n) begin
            for (int c = 0; c < NTAP; c++) prod_q[c] <= '0;
            sum_q      <= '0;
            prod_valid <= 1'b0;
            sum_valid  <= 1'b0;
        end else if (advance) begin
            for (int c = 0; c < NTAP; c++) prod_q[c] <= prod_c[c];
            sum_q      <= sum_c;
            prod_valid <= taps_valid;
            sum_valid  <= prod_valid;
        end
    end
endmodule

// File: rtl/conv_round.sv
module conv_round
    import conv_pkg::*;
#(
    parameter int SUM_W   = conv_pkg::SUM_W,
    parameter int OUT_W   = conv_pkg::OUT_W,
    parameter int HI_KEEP = conv_pkg::HI_KEEP,
    parameter int LO_KEEP = conv_pkg::LO_KEEP
) (
    input  logic                    clk,
    input  logic                    frame_n,
    input  logic                    advance,
    input  rnd_mode_t               rnd,
    input  logic signed [SUM_W-1:0] sum_in,
    input  logic                    sum_valid,
    output logic [OUT_W-1:0]        out_data,
    output logic                    out_valid
);
    localparam int DROP_HI = OUT_W - HI_KEEP;
    localparam int DROP_LO = OUT_W - LO_KEEP;

    logic [SUM_W-1:0] bias;
    logic [SUM_W-1:0] keep_mask;
    logic [SUM_W-1:0] rounded;

    always_comb begin
        bias      = '0;
        keep_mask = '1;
        unique case (rnd)
            RND_TO16: begin
                bias      = SUM_W'(1) << (DROP_HI - 1);
                keep_mask = {SUM_W{1'b1}} << DROP_HI;
            end
            RND_TO8: begin
                bias      = SUM_W'(1) << (DROP_LO - 1);
                keep_mask = {SUM_W{1'b1}} << DROP_LO;
            end
            default: begin
                bias      = '0;
                keep_mask = '1;
            end
        endcase
        rounded = ($unsigned(sum_in) + bias) & keep_mask;
    end

    always_ff @(posedge clk or negedge frame_n) begin
        if (!frame_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else if (advance) begin
            out_data  <= rounded[OUT_W-1:0];
            out_valid <= sum_valid;
        end
    end
endmodule

// File: rtl/conv3x3_engine.sv
module conv3x3_engine
    import conv_pkg::*;
#(
    parameter int PIX_W  = conv_pkg::PIX_W,
    parameter int COEF_W = conv_pkg::COEF_W,
    parameter int OUT_W  = conv_pkg::OUT_W,
    parameter int KDIM   = conv_pkg::KDIM
) (
    input  logic                          clk,
    input  logic                          frame_n,
    input  logic                          hold,
    input  logic [3:0]                    cfg_mode,
    input  logic [KDIM*KDIM*COEF_W-1:0]   coef_vec,
    input  logic [KDIM*PIX_W-1:0]         pix_rows,
    input  logic                          in_valid,
    output logic [OUT_W-1:0]              out_data,
    output logic                          out_valid
);
    localparam int NTAP  = KDIM * KDIM;
    localparam int SUM_W = PIX_W + COEF_W + 2 + $clog2(NTAP);

    cfg_t                        cfg;
    pipe_state_t                 state;
    logic                        advance;
    logic [KDIM-1:0][PIX_W-1:0]  rows;
    logic [NTAP-1:0][COEF_W-1:0] coefs;
    logic [NTAP-1:0][PIX_W-1:0]  taps;
    logic                        taps_valid;
    logic                        prod_valid;
    logic                        sum_valid;
    logic signed [SUM_W-1:0]     sum_q;

    assign cfg   = cfg_t'(cfg_mode);
    assign rows  = pix_rows;
    assign coefs = coef_vec;

    conv_ctrl #(.NSTG(4)) u_ctrl (
        .clk      (clk),
        .frame_n  (frame_n),
        .hold     (hold),
        .in_valid (in_valid),
        .vld_pipe ({taps_valid, prod_valid, sum_valid, out_valid}),
        .state    (state),
        .advance  (advance)
    );

    conv_window #(.PIX_W(PIX_W), .KDIM(KDIM)) u_window (
        .clk        (clk),
        .frame_n    (frame_n),
        .advance    (advance),
        .two_d      (cfg.two_d),
        .in_valid   (in_valid),
        .rows_in    (rows),
        .taps       (taps),
        .taps_valid (taps_valid)
    );

    conv_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .NTAP(NTAP), .SUM_W(SUM_W)) u_mac (
        .clk         (clk),
        .frame_n     (frame_n),
        .advance     (advance),
        .signed_mode (cfg.signed_mode),
        .taps        (taps),
        .coefs       (coefs),
        .taps_valid  (taps_valid),
        .sum_q       (sum_q),
        .prod_valid  (prod_valid),
        .sum_valid   (sum_valid)
    );

    conv_round #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_round (
        .clk       (clk),
        .frame_n   (frame_n),
        .advance   (advance),
        .rnd       (cfg.rnd),
        .sum_in    (sum_q),
        .sum_valid (sum_valid),
        .out_data  (out_data),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/conv_checker.sv
module conv_checker #(
    parameter int OUT_W = conv_pkg::OUT_W
) (
    input logic             clk,
    input logic             frame_n,
    input logic             hold,
    input logic             advance,
    input logic [3:0]       cfg_mode,
    input logic [OUT_W-1:0] out_data,
    input logic             out_valid
);
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!frame_n)
        hold |-> ##2 ($stable(out_data) && $stable(out_valid)))
        else $error("hold did not freeze the output"); // R9

    AST_RND16_LOW_ZERO: assert property (@(posedge clk) disable iff (!frame_n)
        (advance && cfg_mode[3:2] == 2'b01) |=> (out_data[3:0] == 4'd0))
        else $error("16-bit rounding left low bits set"); // R6

    AST_RND8_LOW_ZERO: assert property (@(posedge clk) disable iff (!frame_n)
        (advance && cfg_mode[3:2] == 2'b10) |=> (out_data[11:0] == 12'd0))
        else $error("8-bit rounding left low bits set"); // R7

    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!frame_n)
        !advance |=> ($stable(out_data) && $stable(out_valid)))
        else $error("output moved on a skipped edge"); // R9

    always @(negedge clk) begin
        if (!frame_n) begin
            AST_FRAME_CLEAR: assert (out_data == '0 && out_valid == 1'b0)
                else $error("frame reset did not clear output"); // R10
        end
    end
endmodule

bind conv3x3_engine conv_checker #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .frame_n   (frame_n),
    .hold      (hold),
    .advance   (advance),
    .cfg_mode  (cfg_mode),
    .out_data  (out_data),
    .out_valid (out_valid)
);

// File: tb/conv3x3_engine_tb_top.sv
`timescale 1ns/1ps
module conv3x3_engine_tb_top;
    localparam int HALF = 5;            // half-period in 0.5 ns units below
    localparam int MAX_CYC = 20000;

    logic        clk = 1'b0;
    logic        frame_n = 1'b0;
    logic        hold = 1'b0;
    logic [3:0]  cfg_mode = 4'd0;
    logic [71:0] coef_vec = '0;
    logic [23:0] pix_rows = '0;
    logic        in_valid = 1'b0;
    logic [19:0] out_data;
    logic        out_valid;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R10";

    // Reference model state: sample histories, delay queue for results.
    int h1[9];
    int hr[3][3];
    int dq_d[$];
    bit dq_v[$];
    int m_out;
    bit m_vld;
    bit m_hold_q;

    always #2.5 clk = ~clk;   // 200 MHz

    conv3x3_engine dut_i (
        .clk(clk), .frame_n(frame_n), .hold(hold), .cfg_mode(cfg_mode),
        .coef_vec(coef_vec), .pix_rows(pix_rows), .in_valid(in_valid),
        .out_data(out_data), .out_valid(out_valid)
    );

    function automatic int to_val(input int raw, input bit sgn);
        return (sgn && raw > 127) ? raw - 256 : raw;
    endfunction

    function automatic int expect_sum();
        int s = 0;
        bit sgn = cfg_mode[0];
        for (int c = 0; c < 9; c++) begin
            int cv = to_val(int'(coef_vec[8*c +: 8]), sgn);
            int pv = cfg_mode[1] ? to_val(hr[c/3][2 - c%3], sgn)
                                 : to_val(h1[8 - c], sgn);
            s += cv * pv;
        end
        if (cfg_mode[3:2] == 2'b01) s = (s + 8) & ~15;
        else if (cfg_mode[3:2] == 2'b10) s = (s + 2048) & ~4095;
        return s & 32'h000F_FFFF;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 9; i++) h1[i] = 0;
        for (int r = 0; r < 3; r++) for (int k = 0; k < 3; k++) hr[r][k] = 0;
        dq_d = '{0, 0, 0};
        dq_v = '{0, 0, 0};
        m_out = 0;
        m_vld = 1'b0;
        m_hold_q = 1'b0;
    endtask

    always @(posedge clk or negedge frame_n) begin
        if (!frame_n) begin
            model_clear();
        end else begin
            if (!m_hold_q) begin
                for (int i = 8; i > 0; i--) h1[i] = h1[i-1];
                h1[0] = int'(pix_rows[7:0]);
                for (int r = 0; r < 3; r++) begin
                    hr[r][2] = hr[r][1];
                    hr[r][1] = hr[r][0];
                    hr[r][0] = int'(pix_rows[8*r +: 8]);
                end
                m_out = dq_d[2];
                m_vld = dq_v[2];
                dq_d = '{expect_sum(), dq_d[0], dq_d[1]};
                dq_v = '{in_valid, dq_v[0], dq_v[1]};
            end
            m_hold_q = hold;
        end
    end

    task automatic check(input string req, input int act, input int exp_v, input string what);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp_v, $time);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(cur_req, int'(out_data), m_out, "out_data");
            check(cur_req, int'(out_valid), int'(m_vld), "out_valid");
        end
    end

    task automatic cyc(input bit v, input bit h);
        @(negedge clk);
        #1;
        pix_rows = {$urandom} & 24'hFF_FFFF;
        in_valid = v;
        hold = h;
    endtask

    task automatic run(input int n, input int hold_pct);
        for (int i = 0; i < n; i++) cyc($urandom_range(0, 3) != 0, $urandom_range(0, 99) < hold_pct);
    endtask

    task automatic restart(input logic [3:0] mode, input bit all_max);
        @(negedge clk);
        #1;
        frame_n = 1'b0;
        hold = 1'b0;
        in_valid = 1'b0;
        #1;
        check("R10", int'(out_data), 0, "out_data during frame reset");
        check("R10", int'(out_valid), 0, "out_valid during frame reset");
        cfg_mode = mode;
        for (int c = 0; c < 9; c++) coef_vec[8*c +: 8] = all_max ? 8'hFF : 8'($urandom);
        @(negedge clk);
        @(negedge clk);
        #1;
        frame_n = 1'b1;
    endtask

    initial begin
        model_clear();
        cmp_on = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", int'(out_data), 0, "reset out_data");
        check("R10", int'(out_valid), 0, "reset out_valid");

        cur_req = "R1"; restart(4'b0000, 1'b0); run(60, 0);   // R1 1-D unsigned
        cur_req = "R3"; restart(4'b0000, 1'b0); run(60, 0);   // R3 tap order
        cur_req = "R5"; restart(4'b0000, 1'b0); run(60, 0);   // R5 rows 1,2 carry noise
        cur_req = "R2"; restart(4'b0001, 1'b0); run(60, 0);   // R2 1-D signed
        cur_req = "R4"; restart(4'b0010, 1'b0); run(60, 0);   // R4 2-D unsigned
        cur_req = "R4"; restart(4'b0011, 1'b0); run(60, 0);   // R4 2-D signed
        cur_req = "R6"; restart(4'b0100, 1'b0); run(40, 0);   // R6 round to 16
        cur_req = "R6"; restart(4'b0111, 1'b0); run(40, 0);
        cur_req = "R7"; restart(4'b1000, 1'b1);               // R7 carry at full scale
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1; pix_rows = 24'hFF_FFFF; in_valid = 1'b1;
        end
        cur_req = "R7"; restart(4'b1011, 1'b0); run(40, 0);
        cur_req = "R7"; restart(4'b1100, 1'b0); run(40, 0);   // code 11 = none
        cur_req = "R9"; restart(4'b0010, 1'b0); run(150, 30); // R9 random hold
        cur_req = "R9"; restart(4'b0001, 1'b0); run(150, 50);

        cur_req = "R8"; restart(4'b0000, 1'b0);               // R8 lone pulse
        cyc(1'b1, 1'b0);
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0);
        run(40, 0);                                           // R8 back-to-back

        cur_req = "R10"; restart(4'b0011, 1'b0); run(30, 10); // R10 mid-stream
        restart(4'b0011, 1'b0); run(30, 0);
        cur_req = "R10"; restart(4'b0000, 1'b0); run(30, 0);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule